// File: doc/BRIEF.md
# Debug Instruction and Data Transfer Chains

This block holds two scan chains that a debug TAP uses to drive a halted core. The instruction chain takes a 32-bit opcode from the debugger, keeps it in an instruction holding register, and hands it to the core as a one-cycle issue strobe each time the TAP enters Run-Test/Idle. The data chain moves 32-bit words in both directions: one buffer carries words toward the core, and the other carries words from the core back to the debugger.

Each chain returns a Ready flag on capture, and that flag gates the update that follows. A debugger can therefore stream opcodes and data without polling. It reads the Ready bits afterwards to find out whether any transfer was dropped. The TAP controller, the instruction register and the core sit outside the block and are seen only through strobes.

Top module: `dbg_xfer_chains`

## Requirements
- R1: After reset, `issue_o`, `rx_valid_o` and `tx_full_o` are 0. The instruction holding register is empty, so entering Run-Test/Idle issues nothing.
- R2: The instruction chain is 33 bits long. The opcode goes in first, bit 0 first (LSB first, `tdo_o` = bit 0 of the chain). Bit 32 is Ready. On capture, bits 0..31 read as 0 and bit 32 reads as the current Ready value.
- R3: Update-DR on the instruction chain loads the shifted opcode only if Ready was 1 at the Capture-DR before it. Otherwise the previously held opcode stays.
- R4: `issue_o` pulses for one cycle, one clock after the first cycle in which `rti_i` is sampled 1. Three conditions must all hold: a chain path is active, Ready is 1, and an opcode is held. In that cycle `opcode_o` carries the held opcode.
- R5: Staying in Run-Test/Idle for several cycles gives a single issue. Each new entry reissues the same held opcode.
- R6: Ready equals `exec_en_i` AND (no opcode outstanding). An issue clears it, and a `done_i` pulse sets it again. While `exec_en_i` is 0, Ready is 0 and nothing issues.
- R7: Write transfer, with the data chain selected and instruction EXTEST:
  - Layout: 34 bits, data bits 0..31 first, Ready at bit 32, nRetry at bit 33.
  - Capture: Ready is 1 when the core-bound buffer is empty, and the data bits read 0.
  - Update: if that Ready was 1, the word is written and `rx_valid_o` is set. A write to a full buffer is ignored.
  - Core side: `rx_ack_i` empties the buffer.
- R8: Read transfer, with the data chain selected and instruction INTEST:
  - Capture: bits 0..31 return the word the core wrote with `tx_we_i`, and Ready returns `tx_full_o`.
  - Update: if that Ready was 1, `tx_full_o` is cleared.
- R9: Chain selection works as follows. Instruction codes are EXTEST=5'h00, INTEST=5'h0C and ITRSEL=5'h1D.
  - The instruction chain is selected by ITRSEL, or by `chain_i`=4 together with EXTEST or INTEST.
  - The data chain is selected by `chain_i`=5 together with EXTEST or INTEST.
  - Entering Run-Test/Idle with either chain selected reissues the held opcode.
  - With any other selection, nothing issues and `tdo_o` is 0.
- R10: The nRetry bit captures as 1 when no opcode is outstanding, and as 0 while the core is still executing one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (TAP strobes are synchronous enables) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| capture_dr_i | input | 1 | TAP in Capture-DR this cycle |
| shift_dr_i | input | 1 | TAP in Shift-DR this cycle |
| update_dr_i | input | 1 | TAP in Update-DR this cycle |
| rti_i | input | 1 | TAP in Run-Test/Idle |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out of the selected chain |
| chain_i | input | 5 | Selected scan chain number |
| ir_i | input | 5 | Current TAP instruction |
| exec_en_i | input | 1 | Debug instruction execution enabled |
| issue_o | output | 1 | One-cycle opcode issue strobe |
| opcode_o | output | 32 | Opcode held for the core |
| done_i | input | 1 | Core finished the issued opcode |
| rx_data_o | output | 32 | Core-bound data word |
| rx_valid_o | output | 1 | Core-bound buffer full |
| rx_ack_i | input | 1 | Core consumed the core-bound word |
| tx_data_i | input | 32 | Word written by the core |
| tx_we_i | input | 1 | Core write strobe |
| tx_full_o | output | 1 | Core-written word awaiting the debugger |

## Verification
Results fall due at three points:
- Issue strobe: visible one clock after the first clock edge at which Run-Test/Idle is sampled. The bench counts pulses only after that clock and a settling delay.
- Buffer flags and data: change at the clock edge that samples Update-DR, `rx_ack_i` or `tx_we_i`, so they are compared at the following falling edge.
- Captured Ready and nRetry bits: frozen at the Capture-DR edge, then read back serially before each shift edge.

A behavioural model in the bench steps on the same edges and is compared with every output at each falling edge.

// File: rtl/dbg_xfer_pkg.sv
package dbg_xfer_pkg;
  typedef struct packed {
    logic capture;
    logic shift;
    logic update;
  } scan_ctl_t;

  typedef enum logic [1:0] {
    DTR_NONE  = 2'd0,
    DTR_WRITE = 2'd1,
    DTR_READ  = 2'd2
  } dtr_op_e;
endpackage

// File: rtl/dbg_itr_chain.sv
module dbg_itr_chain
  import dbg_xfer_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  scan_ctl_t         ctl_i,
  input  logic              tdi_i,
  input  logic              ready_i,
  output logic              tdo_o,
  output logic [DATA_W-1:0] itr_o,
  output logic              itr_valid_o
);
  localparam int unsigned LEN = DATA_W + 1;

  logic [LEN-1:0]    sr_q;
  logic              cap_rdy_q;
  logic [DATA_W-1:0] itr_q;
  logic              valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q      <= '0;
      cap_rdy_q <= 1'b0;
      itr_q     <= '0;
      valid_q   <= 1'b0;
    end else if (sel_i) begin
      if (ctl_i.capture) begin
        // only the Ready bit carries information on capture
        sr_q      <= {ready_i, {DATA_W{1'b0}}};
        cap_rdy_q <= ready_i;
      end else if (ctl_i.shift) begin
        sr_q <= {tdi_i, sr_q[LEN-1:1]};
      end else if (ctl_i.update && cap_rdy_q) begin
        itr_q   <= sr_q[DATA_W-1:0];
        valid_q <= 1'b1;
      end
    end
  end

  assign tdo_o       = sr_q[0];
  assign itr_o       = itr_q;
  assign itr_valid_o = valid_q;
endmodule

// File: rtl/dbg_dtr_chain.sv
module dbg_dtr_chain
  import dbg_xfer_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  dtr_op_e           op_i,
  input  scan_ctl_t         ctl_i,
  input  logic              tdi_i,
  input  logic              nretry_i,
  output logic              tdo_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ack_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_we_i,
  output logic              tx_full_o
);
  localparam int unsigned LEN = DATA_W + 2;

  logic [LEN-1:0]    sr_q;
  logic              cap_rdy_q;
  logic [DATA_W-1:0] rx_q;
  logic              rx_full_q;
  logic [DATA_W-1:0] tx_q;
  logic              tx_full_q;
  logic              upd_wr;
  logic              upd_rd;

  assign upd_wr = sel_i && ctl_i.update && cap_rdy_q && (op_i == DTR_WRITE);
  assign upd_rd = sel_i && ctl_i.update && cap_rdy_q && (op_i == DTR_READ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q      <= '0;
      cap_rdy_q <= 1'b0;
    end else if (sel_i) begin
      if (ctl_i.capture) begin
        unique case (op_i)
          DTR_WRITE: begin
            sr_q      <= {nretry_i, ~rx_full_q, {DATA_W{1'b0}}};
            cap_rdy_q <= ~rx_full_q;
          end
          DTR_READ: begin
            sr_q      <= {nretry_i, tx_full_q, tx_q};
            cap_rdy_q <= tx_full_q;
          end
          default: begin
            sr_q      <= '0;
            cap_rdy_q <= 1'b0;
          end
        endcase
      end else if (ctl_i.shift) begin
        sr_q <= {tdi_i, sr_q[LEN-1:1]};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q      <= '0;
      rx_full_q <= 1'b0;
    end else if (upd_wr) begin
      rx_q      <= sr_q[DATA_W-1:0];
      rx_full_q <= 1'b1;
    end else if (rx_ack_i) begin
      rx_full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q      <= '0;
      tx_full_q <= 1'b0;
    end else if (tx_we_i) begin
      tx_q      <= tx_data_i;
      tx_full_q <= 1'b1;
    end else if (upd_rd) begin
      tx_full_q <= 1'b0;
    end
  end

  assign tdo_o      = sr_q[0];
  assign rx_data_o  = rx_q;
  assign rx_valid_o = rx_full_q;
  assign tx_full_o  = tx_full_q;
endmodule

// File: rtl/dbg_issue_ctrl.sv
module dbg_issue_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rti_i,
  input  logic path_i,
  input  logic exec_en_i,
  input  logic itr_valid_i,
  input  logic done_i,
  output logic ready_o,
  output logic busy_o,
  output logic issue_o
);
  logic rti_q;
  logic busy_q;
  logic issue_q;
  logic fire;

  assign ready_o = exec_en_i && !busy_q;
  // one issue per entry into Run-Test/Idle, not per cycle spent there
  assign fire    = rti_i && !rti_q && path_i && ready_o && itr_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rti_q   <= 1'b0;
      busy_q  <= 1'b0;
      issue_q <= 1'b0;
    end else begin
      rti_q   <= rti_i;
      issue_q <= fire;
      if (fire)        busy_q <= 1'b1;
      else if (done_i) busy_q <= 1'b0;
    end
  end

  assign busy_o  = busy_q;
  assign issue_o = issue_q;
endmodule

// File: rtl/dbg_xfer_chains.sv
module dbg_xfer_chains
  import dbg_xfer_pkg::*;
#(
  parameter int unsigned  DATA_W    = 32,
  parameter int unsigned  IR_W      = 5,
  parameter int unsigned  CHAIN_W   = 5,
  parameter logic [4:0]   IR_EXTEST = 5'h00,
  parameter logic [4:0]   IR_INTEST = 5'h0C,
  parameter logic [4:0]   IR_ITRSEL = 5'h1D,
  parameter int unsigned  CHAIN_ITR = 4,
  parameter int unsigned  CHAIN_DTR = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               capture_dr_i,
  input  logic               shift_dr_i,
  input  logic               update_dr_i,
  input  logic               rti_i,
  input  logic               tdi_i,
  output logic               tdo_o,
  input  logic [CHAIN_W-1:0] chain_i,
  input  logic [IR_W-1:0]    ir_i,
  input  logic               exec_en_i,
  output logic               issue_o,
  output logic [DATA_W-1:0]  opcode_o,
  input  logic               done_i,
  output logic [DATA_W-1:0]  rx_data_o,
  output logic               rx_valid_o,
  input  logic               rx_ack_i,
  input  logic [DATA_W-1:0]  tx_data_i,
  input  logic               tx_we_i,
  output logic               tx_full_o
);
  localparam logic [IR_W-1:0]    IrExt  = IR_W'(IR_EXTEST);
  localparam logic [IR_W-1:0]    IrInt  = IR_W'(IR_INTEST);
  localparam logic [IR_W-1:0]    IrSel  = IR_W'(IR_ITRSEL);
  localparam logic [CHAIN_W-1:0] ChItr  = CHAIN_W'(CHAIN_ITR);
  localparam logic [CHAIN_W-1:0] ChDtr  = CHAIN_W'(CHAIN_DTR);

  scan_ctl_t ctl;
  dtr_op_e   dtr_op;
  logic      ir_data;
  logic      sel_itr;
  logic      sel_dtr;
  logic      ready;
  logic      busy;
  logic      itr_valid;
  logic      itr_tdo;
  logic      dtr_tdo;

  assign ctl     = '{capture: capture_dr_i, shift: shift_dr_i, update: update_dr_i};
  assign ir_data = (ir_i == IrExt) || (ir_i == IrInt);
  assign sel_itr = (ir_i == IrSel) || ((chain_i == ChItr) && ir_data);
  assign sel_dtr = (chain_i == ChDtr) && ir_data;
  assign dtr_op  = (ir_i == IrExt) ? DTR_WRITE :
                   (ir_i == IrInt) ? DTR_READ  : DTR_NONE;

  dbg_itr_chain #(.DATA_W(DATA_W)) u_itr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (sel_itr),
    .ctl_i       (ctl),
    .tdi_i       (tdi_i),
    .ready_i     (ready),
    .tdo_o       (itr_tdo),
    .itr_o       (opcode_o),
    .itr_valid_o (itr_valid)
  );

  dbg_dtr_chain #(.DATA_W(DATA_W)) u_dtr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel_dtr),
    .op_i       (dtr_op),
    .ctl_i      (ctl),
    .tdi_i      (tdi_i),
    .nretry_i   (~busy),
    .tdo_o      (dtr_tdo),
    .rx_data_o  (rx_data_o),
    .rx_valid_o (rx_valid_o),
    .rx_ack_i   (rx_ack_i),
    .tx_data_i  (tx_data_i),
    .tx_we_i    (tx_we_i),
    .tx_full_o  (tx_full_o)
  );

  dbg_issue_ctrl u_issue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rti_i       (rti_i),
    .path_i      (sel_itr || sel_dtr),
    .exec_en_i   (exec_en_i),
    .itr_valid_i (itr_valid),
    .done_i      (done_i),
    .ready_o     (ready),
    .busy_o      (busy),
    .issue_o     (issue_o)
  );

  assign tdo_o = sel_itr ? itr_tdo : (sel_dtr ? dtr_tdo : 1'b0);
endmodule

// File: rtl/dbg_xfer_chains_chk.sv
module dbg_xfer_chains_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rti_i,
  input logic              exec_en_i,
  input logic              update_dr_i,
  input logic              issue_o,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              rx_valid_o,
  input logic              rx_ack_i,
  input logic              tx_we_i,
  input logic              tx_full_o
);
  a_r4_issue_on_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |-> ($past(rti_i) && !$past(rti_i, 2)));

  a_r5_single_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |=> !issue_o);

  a_r6_issue_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |-> $past(exec_en_i));

  a_r7_rx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rx_ack_i) |=> (rx_valid_o && $stable(rx_data_o)));

  a_r8_tx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_full_o && !update_dr_i) |=> tx_full_o);

  // nothing may be pending right after reset is released
  a_r1_reset_idle: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (!issue_o && !rx_valid_o && (!tx_full_o || $past(tx_we_i))));
endmodule

bind dbg_xfer_chains dbg_xfer_chains_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rti_i       (rti_i),
  .exec_en_i   (exec_en_i),
  .update_dr_i (update_dr_i),
  .issue_o     (issue_o),
  .rx_data_o   (rx_data_o),
  .rx_valid_o  (rx_valid_o),
  .rx_ack_i    (rx_ack_i),
  .tx_we_i     (tx_we_i),
  .tx_full_o   (tx_full_o)
);

// File: tb/tb_dbg_xfer_chains.sv
`timescale 1ns/1ps
module tb_dbg_xfer_chains;
  localparam logic [4:0] EXT = 5'h00, INT = 5'h0C, SEL = 5'h1D;

  logic clk = 0, rst_n = 0;
  logic capture = 0, shift = 0, update = 0, rti = 0, tdi = 0;
  logic [4:0] chain = 0, ir = SEL;
  logic exec_en = 0, done = 0, rx_ack = 0, tx_we = 0;
  logic [31:0] tx_data = 0;
  logic tdo, issue, rx_valid, tx_full;
  logic [31:0] opcode, rx_data;

  int checks = 0, bad = 0, n_iss = 0, cyc = 0;
  logic [31:0] last_op = 0, scan_word = 0;

  // reference model state
  logic m_rti, m_busy, m_issue, m_itr_ok, m_cap4, m_cap5, m_rx_full, m_tx_full;
  logic [31:0] m_itr, m_rx_data, m_tx_data;

  always #10 clk = ~clk;

  dbg_xfer_chains dut (
    .clk_i(clk), .rst_ni(rst_n), .capture_dr_i(capture), .shift_dr_i(shift),
    .update_dr_i(update), .rti_i(rti), .tdi_i(tdi), .tdo_o(tdo), .chain_i(chain),
    .ir_i(ir), .exec_en_i(exec_en), .issue_o(issue), .opcode_o(opcode), .done_i(done),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_ack_i(rx_ack),
    .tx_data_i(tx_data), .tx_we_i(tx_we), .tx_full_o(tx_full));

  task automatic chk(input bit ok, input string tag, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin : model
    logic idata, s4, s5, rdy, fire;
    if (!rst_n) begin
      m_rti <= 0; m_busy <= 0; m_issue <= 0; m_itr_ok <= 0; m_cap4 <= 0; m_cap5 <= 0;
      m_rx_full <= 0; m_tx_full <= 0; m_itr <= 0; m_rx_data <= 0; m_tx_data <= 0;
    end else begin
      idata = (ir == EXT) || (ir == INT);
      s4    = (ir == SEL) || (chain == 5'd4 && idata);
      s5    = (chain == 5'd5) && idata;
      rdy   = exec_en && !m_busy;
      fire  = rti && !m_rti && (s4 || s5) && rdy && m_itr_ok;
      m_rti   <= rti;
      m_issue <= fire;
      if (fire) m_busy <= 1; else if (done) m_busy <= 0;
      if (s4 && capture) m_cap4 <= rdy;
      if (s4 && update && m_cap4) begin m_itr <= scan_word; m_itr_ok <= 1; end
      if (s5 && capture) m_cap5 <= (ir == EXT) ? !m_rx_full : m_tx_full;
      if (s5 && update && ir == EXT && m_cap5) begin m_rx_full <= 1; m_rx_data <= scan_word; end
      else if (rx_ack) m_rx_full <= 0;
      if (tx_we) begin m_tx_full <= 1; m_tx_data <= tx_data; end
      else if (s5 && update && ir == INT && m_cap5) m_tx_full <= 0;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) if (rst_n) begin
    chk(issue === m_issue, "R4 issue", {33'b0, issue}, {33'b0, m_issue});
    if (issue) begin
      n_iss++;
      last_op = opcode;
      chk(opcode === m_itr, "R4 opcode", {2'b0, opcode}, {2'b0, m_itr});
    end
    chk(rx_valid === m_rx_full, "R7 rx_valid", {33'b0, rx_valid}, {33'b0, m_rx_full});
    if (m_rx_full) chk(rx_data === m_rx_data, "R7 rx_data", {2'b0, rx_data}, {2'b0, m_rx_data});
    chk(tx_full === m_tx_full, "R8 tx_full", {33'b0, tx_full}, {33'b0, m_tx_full});
  end

  task automatic scan(input int len, input logic [31:0] w, output logic [33:0] got);
    logic [33:0] pat;
    pat = {2'b00, w};
    got = '0;
    scan_word = w;
    @(negedge clk) capture = 1;
    @(negedge clk) begin capture = 0; shift = 1; end
    for (int i = 0; i < len; i++) begin
      tdi = pat[i];
      got[i] = tdo;
      @(negedge clk);
    end
    shift = 0; tdi = 0; update = 1;
    @(negedge clk) update = 0;
  endtask

  task automatic idle(input int n, output int delta);
    int start;
    start = n_iss;
    @(negedge clk) rti = 1;
    repeat (n) @(negedge clk);
    rti = 0;
    @(negedge clk); #1;
    delta = n_iss - start;
  endtask

  task automatic pulse_done();
    @(negedge clk) done = 1;
    @(negedge clk) done = 0;
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk) cyc++;
      if (cyc > 20000) begin
        bad++; checks++;
        $display("FAIL watchdog act=%0d exp=<20000", cyc);
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
      end
    end
  end

  initial begin : stim
    logic [33:0] g;
    int d;
    repeat (3) @(negedge clk);
    chk(!issue && !rx_valid && !tx_full, "R1 reset outputs", {31'b0, issue, rx_valid, tx_full}, 0);
    rst_n = 1;
    exec_en = 1; ir = SEL;
    idle(2, d);
    chk(d == 0, "R1 empty itr no issue", d, 0);

    scan(33, 32'hA5A5_0F0F, g);
    chk(g[31:0] == 0, "R2 capture opcode bits zero", g, 0);
    chk(g[32] == 1'b1, "R2 capture ready", g[32], 1);
    idle(4, d);
    chk(d == 1, "R5 one issue per entry", d, 1);
    chk(last_op == 32'hA5A5_0F0F, "R4 opcode issued", last_op, 32'hA5A5_0F0F);
    idle(2, d);
    chk(d == 0, "R6 busy blocks issue", d, 0);
    pulse_done();
    idle(2, d);
    chk(d == 1, "R5 reentry reissues", d, 1);

    scan(33, 32'h1234_5678, g);
    chk(g[32] == 1'b0, "R6 ready low while busy", g[32], 0);
    pulse_done();
    idle(1, d);
    chk(d == 1 && last_op == 32'hA5A5_0F0F, "R3 update ignored when not ready", last_op, 32'hA5A5_0F0F);
    pulse_done();

    exec_en = 0;
    scan(33, 32'h1234_5678, g);
    chk(g[32] == 1'b0, "R6 ready low when disabled", g[32], 0);
    idle(2, d);
    chk(d == 0, "R6 no issue when disabled", d, 0);
    exec_en = 1;
    scan(33, 32'h1234_5678, g);
    chk(g[32] == 1'b1, "R3 ready back", g[32], 1);
    idle(1, d);
    chk(d == 1 && last_op == 32'h1234_5678, "R3 new opcode loaded", last_op, 32'h1234_5678);
    pulse_done();

    chain = 5; ir = EXT;
    scan(34, 32'hDEAD_BEEF, g);
    chk(g[32] == 1'b1, "R7 write ready when empty", g[32], 1);
    chk(g[33] == 1'b1, "R10 nretry idle core", g[33], 1);
    chk(rx_valid && rx_data == 32'hDEAD_BEEF, "R7 word written", rx_data, 32'hDEAD_BEEF);
    scan(34, 32'h0BAD_F00D, g);
    chk(g[32] == 1'b0, "R7 write ready low when full", g[32], 0);
    chk(rx_data == 32'hDEAD_BEEF, "R7 write to full ignored", rx_data, 32'hDEAD_BEEF);
    @(negedge clk) rx_ack = 1;
    @(negedge clk) rx_ack = 0;
    chk(!rx_valid, "R7 ack empties", rx_valid, 0);
    scan(34, 32'hCAFE_0001, g);
    chk(rx_valid && rx_data == 32'hCAFE_0001, "R7 second word", rx_data, 32'hCAFE_0001);
    @(negedge clk) rx_ack = 1;
    @(negedge clk) rx_ack = 0;

    idle(1, d);
    chk(d == 1 && last_op == 32'h1234_5678, "R9 data chain reissues", d, 1);
    ir = INT;
    scan(34, 32'h0, g);
    chk(g[33] == 1'b0, "R10 nretry while busy", g[33], 0);
    chk(g[32] == 1'b0, "R8 read ready low when empty", g[32], 0);
    pulse_done();

    @(negedge clk) begin tx_we = 1; tx_data = 32'h5A5A_C3C3; end
    @(negedge clk) tx_we = 0;
    scan(34, 32'h0, g);
    chk(g[31:0] == 32'h5A5A_C3C3, "R8 read data", g[31:0], 32'h5A5A_C3C3);
    chk(g[32] == 1'b1, "R8 read ready", g[32], 1);
    chk(!tx_full, "R8 read clears full", tx_full, 0);
    scan(34, 32'h0, g);
    chk(g[32] == 1'b0, "R8 second read not ready", g[32], 0);

    chain = 2; ir = EXT;
    scan(34, 32'hFFFF_FFFF, g);
    chk(g == 0, "R9 unselected tdo zero", g, 0);
    idle(2, d);
    chk(d == 0, "R9 unselected no issue", d, 0);
    chain = 4; ir = INT;
    idle(2, d);
    chk(d == 1, "R9 chain4 intest reissues", d, 1);
    pulse_done();

    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule